// File: doc/BRIEF.md
# Receive Character Buffer with Line Status

This block sits between a serial receiver and a host bus interface. Every character the receiver finishes is written in with its own three error flags (parity, framing, break). The block keeps these characters in first-in first-out order and shows the oldest one to the host. Beside it, the block presents a status byte that tells the host whether data is waiting, whether a character was lost, and which errors belong to the character now at the head.

The buffer runs in one of two modes. In queue mode it holds up to `DEPTH` characters. In single mode it acts as one holding register. The error flags travel with their character, so the host sees a character's parity, framing or break condition only while that character is at the head. A lost-character (overrun) indication is different: it is raised at once and is not tied to any stored entry. A line-status interrupt request is raised whenever any error bit is visible and the interrupt is enabled.

Top module: `rx_status_fifo`

## Requirements
- R1: Status bit 0 (data waiting) is 1 from the cycle after a character is accepted. It stays 1 until the last buffered character has been taken by a data read, and it then reads 0 in the following cycle.
- R2: In queue mode (`fifo_mode`=1) the buffer holds `DEPTH` characters. In single mode it holds one. Characters leave in arrival order. `head_char` shows the oldest character and reads 0 when the buffer is empty. A data read on an empty buffer has no effect.
- R3: If a character arrives while the buffer is full and there is no data read in the same cycle, status bit 1 (overrun) is 1 from the next cycle. That character is discarded and the stored characters are unchanged.
- R4: A data read and a receiver write in the same cycle on a full buffer remove the head and store the new character, with no overrun.
- R5: `wr_perr`, `wr_ferr` and `wr_brk` are stored with their character. They show as status bits 2, 3 and 4 respectively, and only while that character is at the head. All three read 0 when the buffer is empty.
- R6: A status read clears bit 1 and the head character's bits 2 to 4 from the next cycle. An overrun occurring in the same cycle as a status read wins, and bit 1 stays 1. Bit 0 is not affected by a status read.
- R7: `lsi_irq` equals `lsi_en` AND (any of status bits 1 to 4). It follows its inputs within the same cycle.
- R8: Status bits 5 to 7 always read 0.
- R9: A change of `fifo_mode` empties the buffer in the next cycle. A write or data read in that cycle is ignored. The overrun bit is not changed by the mode change itself.
- R10: After reset the buffer is empty, in single mode, and the status byte, `head_char` and `lsi_irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_mode | input | 1 | 1 selects queue mode, 0 selects single-register mode |
| wr_valid | input | 1 | Receiver has completed a character this cycle |
| wr_char | input | 8 | Received character |
| wr_perr | input | 1 | Parity error for this character |
| wr_ferr | input | 1 | Framing error for this character |
| wr_brk | input | 1 | Break detected for this character |
| rd_data | input | 1 | Host reads the data register (pops the head) |
| rd_status | input | 1 | Host reads the status register |
| lsi_en | input | 1 | Line-status interrupt enable |
| status | output | 8 | Status byte |
| head_char | output | 8 | Oldest buffered character |
| lsi_irq | output | 1 | Line-status interrupt request |

## Verification
Several properties are checked on every cycle:
- data waiting follows any accepted write;
- occupancy never exceeds the mode's capacity;
- a dropped character sets overrun while the head stays put;
- a swap on a full buffer raises no overrun;
- a status read clears overrun unless a drop collides with it;
- a mode change empties the buffer.

Other behaviour can only be shown by the bench scenarios, where a queue-based model is compared on every clock:
- arrival order;
- errors becoming visible as each character reaches the head;
- clearing only the head's flags;
- interrupt gating.

The scenarios cover full and empty edges in both modes, and also mixed random traffic.

// File: rtl/rx_status_fifo.sv
module rx_status_fifo #(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifo_mode,
  input  logic       wr_valid,
  input  logic [7:0] wr_char,
  input  logic       wr_perr,
  input  logic       wr_ferr,
  input  logic       wr_brk,
  input  logic       rd_data,
  input  logic       rd_status,
  input  logic       lsi_en,
  output logic [7:0] status,
  output logic [7:0] head_char,
  output logic       lsi_irq
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [7:0]    ch_mem [DEPTH];
  logic [2:0]    er_mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  logic          ovr_q, mode_q;

  wire           flush    = fifo_mode != mode_q;
  wire [CW-1:0]  cap      = mode_q ? CW'(DEPTH) : CW'(1);
  wire           empty    = count == '0;
  wire           full     = count == cap;
  wire           pop      = rd_data && !empty && !flush;
  wire           push     = wr_valid && !flush && (!full || pop);
  wire           drop     = wr_valid && !flush && full && !pop;
  wire           clr_head = rd_status && !empty && !pop && !flush;
  wire [2:0]     head_err = empty ? 3'b000 : er_mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
      ovr_q  <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      mode_q <= fifo_mode;
      if (flush) begin
        rd_ptr <= '0;
        wr_ptr <= '0;
        count  <= '0;
      end else begin
        if (pop)  rd_ptr <= bump(rd_ptr);
        if (push) wr_ptr <= bump(wr_ptr);
        if (push && !pop)      count <= count + 1'b1;
        else if (pop && !push) count <= count - 1'b1;
      end
      if (drop)           ovr_q <= 1'b1;
      else if (rd_status) ovr_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (clr_head) er_mem[rd_ptr] <= 3'b000;
    if (push) begin
      ch_mem[wr_ptr] <= wr_char;
      er_mem[wr_ptr] <= {wr_brk, wr_ferr, wr_perr};
    end
  end

  assign status    = {3'b000, head_err, ovr_q, !empty};
  assign head_char = empty ? 8'h00 : ch_mem[rd_ptr];
  assign lsi_irq   = lsi_en && (ovr_q || (head_err != 3'b000));

  a_r1_ready_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !flush) |=> status[0]);
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= cap);
  a_r3_drop_keeps_head: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> (status[1] && $stable(head_char) && status[0]));
  a_r4_full_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && rd_data && full && !flush && !ovr_q) |=> !status[1]);
  a_r6_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && !drop) |=> !status[1]);
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !status[0]);
endmodule

// File: tb/rx_status_fifo_tb.sv
module rx_status_fifo_tb_top;
  localparam int DEPTH = 16;
  logic clk = 0, rst_n = 0;
  logic fifo_mode = 0, wr_valid = 0, wr_perr = 0, wr_ferr = 0, wr_brk = 0;
  logic rd_data = 0, rd_status = 0, lsi_en = 0;
  logic [7:0] wr_char = 0;
  logic [7:0] status, head_char;
  logic lsi_irq;

  always #5 clk = ~clk;

  rx_status_fifo #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .wr_valid(wr_valid),
    .wr_char(wr_char), .wr_perr(wr_perr), .wr_ferr(wr_ferr), .wr_brk(wr_brk),
    .rd_data(rd_data), .rd_status(rd_status), .lsi_en(lsi_en),
    .status(status), .head_char(head_char), .lsi_irq(lsi_irq));

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] qc[$];
  logic [2:0] qe[$];
  bit m_ovr = 0, m_mode = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    logic [2:0] e = (qc.size() != 0) ? qe[0] : 3'b000;
    logic [7:0] es = {3'b000, e, m_ovr, qc.size() != 0};
    logic [7:0] eh = (qc.size() != 0) ? qc[0] : 8'h00;
    bit ei = lsi_en && (es[4:1] != 0);
    chk(status[0] == es[0], {"R1 ready ", tag}, status[0], es[0]);
    chk(status[1] == es[1], {"R3 overrun ", tag}, status[1], es[1]);
    chk(status[4:2] == es[4:2], {"R5 errors ", tag}, status[4:2], es[4:2]);
    chk(status[7:5] == 3'b000, "R8 upper bits", status[7:5], 0);
    chk(head_char == eh, {"R2 head ", tag}, head_char, eh);
    chk(lsi_irq == ei, {"R7 irq ", tag}, lsi_irq, ei);
  endtask

  task automatic step(input bit wv, input logic [7:0] ch, input logic [2:0] er,
                      input bit rdd, input bit rds, input bit en, input bit md,
                      input string tag);
    int cap;
    bit full, pop;
    wr_valid = wv; wr_char = ch; {wr_brk, wr_ferr, wr_perr} = er;
    rd_data = rdd; rd_status = rds; lsi_en = en; fifo_mode = md;
    #1 compare(tag);
    @(posedge clk);
    if (md != m_mode) begin
      qc.delete(); qe.delete();
      m_mode = md;
      if (rds) m_ovr = 0;
    end else begin
      cap  = m_mode ? DEPTH : 1;
      full = qc.size() == cap;
      pop  = rdd && qc.size() != 0;
      if (rds && qc.size() != 0 && !pop) qe[0] = 3'b000;
      if (pop) begin void'(qc.pop_front()); void'(qe.pop_front()); end
      if (wv && full && !pop) m_ovr = 1;
      else if (rds) m_ovr = 0;
      if (wv && !(full && !pop)) begin qc.push_back(ch); qe.push_back(er); end
    end
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    lsi_en = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(status == 8'h00, "R10 reset status", status, 0);
    chk(head_char == 8'h00, "R10 reset head", head_char, 0);
    chk(lsi_irq == 1'b0, "R10 reset irq", lsi_irq, 0);
    // single mode: hold, overrun, status clear
    step(1, 8'hA5, 3'b001, 0, 0, 1, 0, "R1 single write");
    step(1, 8'h3C, 3'b000, 0, 0, 1, 0, "R3 single overrun");
    step(0, 0, 0, 0, 0, 1, 0, "R3 observe");
    step(1, 8'h11, 3'b100, 0, 1, 1, 0, "R6 drop during status read");
    step(0, 0, 0, 0, 1, 1, 0, "R6 status read");
    step(0, 0, 0, 1, 0, 1, 0, "R1 read last");
    step(0, 0, 0, 1, 0, 1, 0, "R2 empty read");
    // mode change with a write in the same cycle
    step(1, 8'h77, 3'b010, 0, 0, 1, 1, "R9 switch");
    step(0, 0, 0, 0, 0, 1, 1, "R9 after");
    // fill queue mode
    for (int i = 0; i < DEPTH; i++)
      step(1, 8'(i * 7 + 1), 3'(i % 8), 0, 0, i[0], 1, "R2 fill");
    step(1, 8'hEE, 3'b111, 0, 0, 1, 1, "R3 full drop");
    step(1, 8'hDD, 3'b010, 1, 0, 1, 1, "R4 swap on full");
    step(0, 0, 0, 0, 1, 1, 1, "R6 clear head");
    step(0, 0, 0, 0, 0, 1, 1, "R6 observe");
    for (int i = 0; i < DEPTH + 2; i++)
      step(0, 0, 0, 1, i[1], i[0], 1, "R5 drain");
    for (int i = 0; i < 5; i++)
      step(1, 8'(i + 40), 3'b101, 0, 0, 1, 1, "R9 refill");
    step(0, 0, 0, 1, 0, 1, 0, "R9 back to single");
    step(0, 0, 0, 0, 0, 1, 0, "R9 empty");
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r = $urandom;
      step(r[0] | r[1], r[15:8], r[18:16], r[2] & r[3], r[4] & r[5] & r[6],
           r[7], (i < 2500) ? 1'b1 : (i % 200 < 100), "mixed");
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule